// File: doc/BRIEF.md
# Stream-Fed Crypto Command Controller

This block is the command front end of a crypto coprocessor. Commands arrive as packets on a 64-bit AXI4-Stream slave port. The destination field of the first beat of a packet acts as an operation code. Up to eight beats are gathered into a shared 512-bit block buffer. For a hash or cipher command, the controller then pulses the start input of the matching worker engine. It waits for that engine's done signal and returns the result on a 64-bit AXI4-Stream master port.

A key-load command is handled differently. It copies part of the buffer into a key register that feeds the cipher engine, and it sends nothing back. The engines sit outside this block and see the buffer and the key as plain wide buses.

Control is a four-state machine: idle, loading, executing, writing out. It contains no data-dependent branching, so for a given operation the delay from the last input beat to the first output beat is set only by the engine's fixed latency.

Top module: `crypto_cmd_ctrl`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `cmd_error` is 0, both start outputs are 0 and `ciph_key` is zero.
- R2: The opcode is the `in_dest` value of the first accepted beat of a command: 1 = key load, 2 = hash, 3 = cipher, any other value = unknown. `in_dest` on later beats of the same command has no effect.
- R3: Beat k of a command (counting from 0) is written to `blk_data[511-64k -: 64]`. The load ends on the beat that carries `in_last`, or on the eighth beat whether or not `in_last` is set. Buffer words not written by the command read as zero.
- R4: `in_ready` is 1 only while idle or loading. It is 0 from the cycle after the final input beat until the command has completed, including all of its output beats.
- R5: In the first execute cycle, exactly one one-cycle pulse goes to the start input of the selected engine. The other engine's start stays 0. Key-load and unknown commands pulse neither.
- R6: A hash command returns the 256-bit digest as four beats, most significant 64 bits first, with `out_last` on the fourth beat only.
- R7: A cipher command returns the 128-bit ciphertext as two beats, most significant half first, with `out_last` on the second beat only.
- R8: A key-load command sets `ciph_key` to `blk_data[511:384]`, produces no output beat, and then returns to accepting input.
- R9: `out_valid` rises in the cycle after the engine's done. With a done that follows start by a fixed N cycles, the last input beat and the first output beat are N+1 clock edges apart, whatever the data.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values and `out_valid` stays 1.
- R11: An unknown-opcode command consumes its beats, produces no output and sets `cmd_error`. `cmd_error` stays 1 until the first beat of a command with a known opcode is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat ready |
| in_data | input | 64 | Input beat data |
| in_dest | input | 3 | Destination field, used as the opcode on the first beat |
| in_last | input | 1 | Final beat of the command |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat ready |
| out_data | output | 64 | Output beat data |
| out_last | output | 1 | Final beat of the result |
| blk_data | output | 512 | Assembled block buffer, read by both engines |
| ciph_key | output | 128 | Stored cipher key |
| hash_start | output | 1 | Start pulse to the hash engine |
| hash_done | input | 1 | Done pulse from the hash engine |
| hash_digest | input | 256 | Digest from the hash engine |
| ciph_start | output | 1 | Start pulse to the cipher engine |
| ciph_done | input | 1 | Done pulse from the cipher engine |
| ciph_text | input | 128 | Ciphertext from the cipher engine |
| cmd_error | output | 1 | Sticky unknown-opcode flag |

## Verification
The assertions assume well-behaved engines. Each engine raises done only after it has been started, at most once per start, and never in the same cycle as its start. The check that `out_valid` rises only after a done depends on this.

The bench's engine models keep to these rules. Each one counts a fixed number of cycles from a sampled start, pulses done for one cycle, and holds its result from the start onward.

The bench drives `in_valid` only from the falling edge. It holds a beat until the beat is accepted, and it varies `out_ready` in a repeating pattern. This covers both stalled and free-flowing output.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EXEC = 2'd2,
    ST_WOUT = 2'd3
  } cc_state_t;

  localparam logic [2:0] OP_KEY  = 3'd1;
  localparam logic [2:0] OP_HASH = 3'd2;
  localparam logic [2:0] OP_CIPH = 3'd3;

  function automatic logic op_known(input logic [2:0] op);
    return (op == OP_KEY) || (op == OP_HASH) || (op == OP_CIPH);
  endfunction
endpackage

// File: rtl/cc_beat_buffer.sv
module cc_beat_buffer #(
  parameter int DW    = 64,
  parameter int BEATS = 8,
  localparam int BUF_W = DW * BEATS,
  localparam int CNTW  = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_first,
  input  logic [CNTW-1:0]  wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [BUF_W-1:0] buf_q
);
  for (genvar g = 0; g < BEATS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wr_en) begin
        if (wr_idx == CNTW'(g)) word_q <= wr_data;
        else if (wr_first)      word_q <= '0;
      end
    end
    assign buf_q[BUF_W-1-g*DW -: DW] = word_q;
  end
endmodule

// File: rtl/cc_serializer.sv
module cc_serializer #(
  parameter int DW    = 64,
  parameter int RES_W = 256,
  localparam int NB   = RES_W / DW,
  localparam int BCW  = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] load_data,
  input  logic [BCW-1:0]   load_beats,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic             fin
);
  logic [RES_W-1:0] sh_q;
  logic [BCW-1:0]   rem_q;
  logic             adv;

  assign out_valid = (rem_q != '0);
  assign out_data  = sh_q[RES_W-1 -: DW];
  assign out_last  = (rem_q == BCW'(1));
  assign adv       = out_valid && out_ready;
  assign fin       = adv && out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load) begin
      sh_q  <= load_data;
      rem_q <= load_beats;
    end else if (adv) begin
      sh_q  <= sh_q << DW;
      rem_q <= rem_q - BCW'(1);
    end
  end
endmodule

// File: rtl/cc_ctrl_fsm.sv
module cc_ctrl_fsm
  import cc_pkg::*;
#(
  parameter int BEATS = 8,
  localparam int CNTW = $clog2(BEATS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_last,
  input  logic [2:0]      in_dest,
  input  logic            hash_done,
  input  logic            ciph_done,
  input  logic            ser_fin,
  output logic            in_ready,
  output logic            wr_en,
  output logic            wr_first,
  output logic [CNTW-1:0] wr_idx,
  output logic            hash_start,
  output logic            ciph_start,
  output logic            ser_load,
  output logic            key_load,
  output logic [2:0]      op_q,
  output logic            err_q
);
  cc_state_t       state_q, state_d;
  logic [CNTW-1:0] cnt_q;
  logic            fresh_q;
  logic            accept, last_beat, err_d;

  always_comb begin
    state_d   = state_q;
    in_ready  = (state_q == ST_IDLE) || (state_q == ST_LOAD);
    accept    = in_valid && in_ready;
    wr_en     = accept;
    wr_first  = (state_q == ST_IDLE);
    wr_idx    = wr_first ? '0 : cnt_q;
    last_beat = accept && (in_last || (wr_idx == CNTW'(BEATS - 1)));
    ser_load  = 1'b0;
    key_load  = 1'b0;
    err_d     = err_q;
    if (accept && wr_first && op_known(in_dest)) err_d = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) state_d = last_beat ? ST_EXEC : ST_LOAD;
      ST_LOAD: if (last_beat) state_d = ST_EXEC;
      ST_EXEC: begin
        case (op_q)
          OP_KEY: begin
            key_load = 1'b1;
            state_d  = ST_IDLE;
          end
          OP_HASH: if (hash_done && !fresh_q) begin
            ser_load = 1'b1;
            state_d  = ST_WOUT;
          end
          OP_CIPH: if (ciph_done && !fresh_q) begin
            ser_load = 1'b1;
            state_d  = ST_WOUT;
          end
          default: begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end
        endcase
      end
      ST_WOUT: if (ser_fin) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    hash_start = (state_q == ST_EXEC) && fresh_q && (op_q == OP_HASH);
    ciph_start = (state_q == ST_EXEC) && fresh_q && (op_q == OP_CIPH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      cnt_q   <= '0;
      fresh_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fresh_q <= (state_d == ST_EXEC) && (state_q != ST_EXEC);
      err_q   <= err_d;
      if (accept && wr_first) op_q  <= in_dest;
      if (accept)             cnt_q <= wr_idx + CNTW'(1);
    end
  end
endmodule

// File: rtl/crypto_cmd_ctrl.sv
module crypto_cmd_ctrl
  import cc_pkg::*;
#(
  parameter int DW     = 64,
  parameter int BEATS  = 8,
  parameter int HASH_W = 256,
  parameter int CIPH_W = 128,
  parameter int KEY_W  = 128,
  localparam int BUF_W = DW * BEATS,
  localparam int CNTW  = $clog2(BEATS),
  localparam int BCW   = $clog2(HASH_W / DW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic [2:0]        in_dest,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_last,
  output logic [BUF_W-1:0]  blk_data,
  output logic [KEY_W-1:0]  ciph_key,
  output logic              hash_start,
  input  logic              hash_done,
  input  logic [HASH_W-1:0] hash_digest,
  output logic              ciph_start,
  input  logic              ciph_done,
  input  logic [CIPH_W-1:0] ciph_text,
  output logic              cmd_error
);
  logic             wr_en, wr_first, ser_load, key_load, ser_fin;
  logic [CNTW-1:0]  wr_idx;
  logic [2:0]       op_q;
  logic [HASH_W-1:0] res_data;
  logic [BCW-1:0]   res_beats;
  logic [KEY_W-1:0] key_q;

  cc_ctrl_fsm #(.BEATS(BEATS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_dest(in_dest), .hash_done(hash_done), .ciph_done(ciph_done),
    .ser_fin(ser_fin), .in_ready(in_ready), .wr_en(wr_en),
    .wr_first(wr_first), .wr_idx(wr_idx), .hash_start(hash_start),
    .ciph_start(ciph_start), .ser_load(ser_load), .key_load(key_load),
    .op_q(op_q), .err_q(cmd_error)
  );

  cc_beat_buffer #(.DW(DW), .BEATS(BEATS)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_first(wr_first),
    .wr_idx(wr_idx), .wr_data(in_data), .buf_q(blk_data)
  );

  always_comb begin
    if (op_q == OP_HASH) begin
      res_data  = hash_digest;
      res_beats = BCW'(HASH_W / DW);
    end else begin
      res_data  = {ciph_text, {(HASH_W - CIPH_W){1'b0}}};
      res_beats = BCW'(CIPH_W / DW);
    end
  end

  cc_serializer #(.DW(DW), .RES_W(HASH_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .load_data(res_data),
    .load_beats(res_beats), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .fin(ser_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        key_q <= '0;
    else if (key_load) key_q <= blk_data[BUF_W-1 -: KEY_W];
  end
  assign ciph_key = key_q;
endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_last,
  input logic          hash_start,
  input logic          ciph_start,
  input logic          hash_done,
  input logic          ciph_done
);
  AST_OUT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R4
  AST_START_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_start || ciph_start) |-> !in_ready); // R4
  AST_HSTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |=> !hash_start); // R5
  AST_CSTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ciph_start |=> !ciph_start); // R5
  AST_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hash_start && ciph_start)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R10
  AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(hash_done || ciph_done)); // R9
endmodule

bind crypto_cmd_ctrl cc_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .hash_start(hash_start), .ciph_start(ciph_start),
  .hash_done(hash_done), .ciph_done(ciph_done)
);

// File: tb/sim_crypto_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_crypto_cmd_ctrl;
  localparam int HLAT = 64;
  localparam int CLAT = 10;
  localparam logic [63:0] HMASK = 64'h0F1E2D3C4B5A6978;
  localparam logic [63:0] CMASK = 64'hC3A55A3C96699669;

  logic clk, rst_n;
  logic in_valid, in_ready, in_last, out_valid, out_ready, out_last;
  logic [63:0] in_data, out_data;
  logic [2:0] in_dest;
  logic [511:0] blk_data;
  logic [127:0] ciph_key, ciph_text;
  logic hash_start, hash_done, ciph_start, ciph_done, cmd_error;
  logic [255:0] hash_digest;

  int n_tests, n_fail;
  logic [63:0] beat_mem [8];
  logic [63:0] exp_mem [4];

  crypto_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_dest(in_dest), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .blk_data(blk_data), .ciph_key(ciph_key),
    .hash_start(hash_start), .hash_done(hash_done), .hash_digest(hash_digest),
    .ciph_start(ciph_start), .ciph_done(ciph_done), .ciph_text(ciph_text),
    .cmd_error(cmd_error)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Engine models: fixed latency, result held from start
  int hcnt, ccnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= 0; ccnt <= 0; hash_digest <= '0; ciph_text <= '0;
    end else begin
      if (hash_start) begin
        hcnt <= HLAT;
        hash_digest <= blk_data[511:256] ^ blk_data[255:0] ^ {4{HMASK}};
      end else if (hcnt != 0) hcnt <= hcnt - 1;
      if (ciph_start) begin
        ccnt <= CLAT;
        ciph_text <= blk_data[511:384] ^ ciph_key ^ {2{CMASK}};
      end else if (ccnt != 0) ccnt <= ccnt - 1;
    end
  end
  assign hash_done = (hcnt == 1);
  assign ciph_done = (ccnt == 1);

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] mk_blk(input int n);
    logic [511:0] b = '0;
    for (int k = 0; k < n; k++) b[511-64*k -: 64] = beat_mem[k];
    return b;
  endfunction

  // Sends n beats; later beats carry a different dest; in_last omitted at n==8
  task automatic send_cmd(input logic [2:0] op, input int n);
    int i = 0;
    bit acc;
    while (i < n) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = beat_mem[i];
      in_dest  = (i == 0) ? op : ~op;
      in_last  = (i == n - 1) && (n < 8);
      #1;
      acc = in_ready;
      @(posedge clk);
      if (acc) i++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // Called at the first negedge after the last beat; returns edges to out_valid
  task automatic measure(output int lat);
    lat = 0;
    while (!out_valid && lat < 500) begin
      @(posedge clk); lat++; @(negedge clk);
    end
  endtask

  task automatic get_result(input int nb, input int seed, input string req);
    int i = 0, cyc = 0;
    bit stalled = 0;
    logic [63:0] prev = '0;
    logic prev_last = 0;
    while (i < nb && cyc < 200) begin
      out_ready = ((cyc + seed) % 3) != 0;
      #1;
      if (stalled)
        chk(out_valid && out_data == prev && out_last == prev_last, "R10",
            {192'd0, out_data}, {192'd0, prev});
      if (out_valid && out_ready) begin
        chk(out_data == exp_mem[i], req, {192'd0, out_data}, {192'd0, exp_mem[i]});
        chk(out_last == (i == nb - 1), req, {255'd0, out_last}, {255'd0, i == nb - 1});
        i++;
      end
      stalled = out_valid && !out_ready;
      prev = out_data; prev_last = out_last;
      @(posedge clk); @(negedge clk); cyc++;
    end
    out_ready = 1'b1;
    #1;
    chk(!out_valid && in_ready, "R4", {254'd0, out_valid, in_ready}, 256'd1);
  endtask

  task automatic do_hash(input int n, input int seed);
    logic [511:0] b;
    logic [255:0] d;
    int lat;
    for (int k = 0; k < 8; k++) beat_mem[k] = {32'(n * 97 + seed), 32'(k * 12345 + seed * 7 + 1)};
    b = mk_blk(n);
    d = b[511:256] ^ b[255:0] ^ {4{HMASK}};
    for (int k = 0; k < 4; k++) exp_mem[k] = d[255-64*k -: 64];
    send_cmd(3'd2, n);
    #1;
    chk(hash_start && !ciph_start && !in_ready, "R5", {253'd0, hash_start, ciph_start, in_ready}, 256'd4);
    chk(blk_data == b, "R3", b[255:0] ^ blk_data[255:0], 256'd0);
    measure(lat);
    chk(lat == HLAT + 1, "R9", 256'(lat), 256'(HLAT + 1));
    get_result(4, seed, "R6");
  endtask

  task automatic do_ciph(input int n, input int seed);
    logic [511:0] b;
    logic [127:0] c;
    int lat;
    for (int k = 0; k < 8; k++) beat_mem[k] = {32'(seed * 31 + k), 32'hDEAD0000 + 32'(k + n)};
    b = mk_blk(n);
    c = b[511:384] ^ ciph_key ^ {2{CMASK}};
    exp_mem[0] = c[127:64]; exp_mem[1] = c[63:0];
    send_cmd(3'd3, n);
    #1;
    chk(ciph_start && !hash_start, "R5", {254'd0, ciph_start, hash_start}, 256'd2);
    measure(lat);
    chk(lat == CLAT + 1, "R9", 256'(lat), 256'(CLAT + 1));
    get_result(2, seed, "R7");
  endtask

  // Commands without output: watch for any beat or start pulse
  task automatic quiet_cmd(input logic [2:0] op, input int n, input string req);
    bit seen = 0;
    send_cmd(op, n);
    for (int c = 0; c < 12; c++) begin
      #1;
      if (out_valid || hash_start || ciph_start) seen = 1;
      @(negedge clk);
    end
    chk(!seen && in_ready, req, {254'd0, seen, in_ready}, 256'd1);
  endtask

  task automatic do_key(input int n, input logic [63:0] k0, input logic [63:0] k1);
    logic [127:0] ek;
    beat_mem[0] = k0; beat_mem[1] = k1; beat_mem[2] = 64'h1111;
    ek = {k0, (n > 1) ? k1 : 64'd0};
    quiet_cmd(3'd1, n, "R8");
    chk(ciph_key == ek, "R8", {128'd0, ciph_key}, {128'd0, ek});
  endtask

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0;
    in_valid = 0; in_data = '0; in_dest = '0; in_last = 0; out_ready = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready && !out_valid && !cmd_error && !hash_start && !ciph_start && ciph_key == '0,
        "R1", {251'd0, in_ready, out_valid, cmd_error, hash_start, ciph_start}, 256'h10);
    // R8 key loads (R2: later beats use a different dest)
    do_key(2, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210);
    do_key(1, 64'h5555AAAA5555AAAA, 64'h7777);
    do_key(3, 64'h00112233_44556677, 64'h8899AABB_CCDDEEFF);
    // R3 R6 R9 hash sweep over every length and several seeds
    for (int s = 0; s < 3; s++)
      for (int n = 1; n <= 8; n++) do_hash(n, s * 5 + n);
    // R7 cipher sweep
    for (int n = 1; n <= 8; n++) do_ciph(n, n + 40);
    // R11 unknown opcodes
    for (int op = 0; op < 8; op++) begin
      if (op >= 1 && op <= 3) continue;
      beat_mem[0] = 64'hABCD; beat_mem[1] = 64'hEF01; beat_mem[2] = 64'h2345;
      quiet_cmd(3'(op), 3, "R11");
      chk(cmd_error, "R11", {255'd0, cmd_error}, 256'd1);
    end
    do_hash(2, 99);
    chk(!cmd_error, "R11", {255'd0, cmd_error}, 256'd0);
    do_key(2, 64'hCAFEF00DCAFEF00D, 64'h0BADBEEF0BADBEEF);
    do_ciph(2, 7);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule